// File: doc/BRIEF.md
# Four-Byte Serial Instruction Shifter

This block is the host side of a serial programming link. It takes one 32-bit instruction word and sends it to a target device as four bytes over a serial clock and a data-out line. While it sends, it captures the four bytes the target returns on its data-in line. The target runs from a slow and uncalibrated clock. For that reason every low and every high phase of the serial clock is held for a fixed number of host clock cycles, `HALF_CYC`. The default of 600 cycles gives 3 us per phase at a 200 MHz host clock, which is more than two target cycles even at the slowest target clock rate.

Instructions enter on a valid/ready stream. A word is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while a transfer runs and also while an earlier response has not yet been collected. This is how a slow consumer of responses holds back new commands.

The returned bytes leave on a second valid/ready stream. The four slots are exposed separately so that the caller can compare the byte returned in the third slot with the second byte it sent, and decide whether the link is in step. When it is not, the caller raises `pulse_req`. The block then makes one clock pulse without moving any data, which slips the target's bit count by one.

Top module: `quad_byte_shifter`

## Requirements
- R1: While reset is applied and on the first cycle after it, `sck`, `mosi`, `busy` and `rsp_valid` are low and `cmd_ready` is high.
- R2: A word is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high, and `busy` is high from the next cycle. `cmd_ready` equals not `busy` and not `rsp_valid`.
- R3: During a transfer, `sck` starts low. Every low phase and every high phase of `sck` lasts exactly `HALF_CYC` host cycles.
- R4: `mosi` carries bit 31 of the accepted word down to bit 0, one bit per `sck` period. Each bit is present from the start of its low phase to the end of its high phase, and `mosi` changes only where `sck` falls.
- R5: `miso` is sampled where `sck` rises. The first 8 samples form `rsp_slot0`, the next 8 form `rsp_slot1`, and so on to `rsp_slot3`. The earliest sample of each slot is that slot's bit 7.
- R6: A transfer has exactly 32 rising edges of `sck` and lasts 64*`HALF_CYC` cycles after acceptance. On its last cycle `sck` falls, `busy` drops, `mosi` returns low and `rsp_valid` rises.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high, the four slots hold their values and no word is accepted. `rsp_valid` drops on the cycle after a handshake.
- R8: `pulse_req` taken while `busy` is low makes one `HALF_CYC` low phase followed by one `HALF_CYC` high phase, with `mosi` held low. It does not raise `rsp_valid` and does not change the slots, even when a response is still pending.
- R9: `pulse_req` has no effect while `busy` is high, or on the edge where a word is accepted. In both cases the transfer still has exactly 32 rising edges of `sck`.
- R10: Whenever `busy` is low, `sck` and `mosi` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Instruction word offered |
| cmd_ready | output | 1 | Block can take a word this cycle |
| cmd_data | input | 32 | Instruction word, bit 31 sent first |
| pulse_req | input | 1 | Request one data-free clock pulse |
| busy | output | 1 | Transfer or pulse in progress |
| rsp_valid | output | 1 | Four returned bytes are available |
| rsp_ready | input | 1 | Consumer takes the returned bytes |
| rsp_slot0 | output | 8 | Byte returned during the first byte slot |
| rsp_slot1 | output | 8 | Byte returned during the second byte slot |
| rsp_slot2 | output | 8 | Byte returned during the third byte slot |
| rsp_slot3 | output | 8 | Byte returned during the fourth byte slot |
| sck | output | 1 | Serial clock to the target |
| mosi | output | 1 | Serial data to the target |
| miso | input | 1 | Serial data from the target |

## Verification
The assertions check, on every cycle, the properties that hold at all times:
- each `sck` phase is never shorter than `HALF_CYC`;
- `mosi` holds still except where `sck` falls;
- both lines are quiet when the block is idle;
- a pending response holds its bytes and blocks new words;
- every completed transfer contained exactly 32 rising edges.

Some behaviours need a target model and chosen stimulus, so only the bench scenarios show them:
- that the bits leave in the right order;
- that each returned bit lands in the correct slot position, including a target that echoes the second command byte in the third slot;
- that a pulse request is served or ignored depending on when it arrives.

// File: rtl/qbs_pkg.sv
`timescale 1ns/1ps
package qbs_pkg;
  // Shape of one instruction frame; fixed by the target's protocol.
  localparam int unsigned QBS_NUM_BYTES  = 4;
  localparam int unsigned QBS_BYTE_W     = 8;
  localparam int unsigned QBS_FRAME_BITS = QBS_NUM_BYTES * QBS_BYTE_W;
  localparam int unsigned QBS_BIT_W      = $clog2(QBS_FRAME_BITS);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } qbs_state_e;
endpackage

// File: rtl/qbs_phase_timer.sv
`timescale 1ns/1ps
module qbs_phase_timer #(
  parameter int unsigned HALF_CYC = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic phase_end
);
  localparam int unsigned CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  assign phase_end = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || phase_end) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/qbs_sequencer.sv
`timescale 1ns/1ps
module qbs_sequencer
  import qbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_go,
  input  logic pulse_go,
  input  logic phase_end,
  output logic run,
  output logic sck,
  output logic frame_on,
  output logic rise_stb,
  output logic fall_stb,
  output logic done_stb
);
  localparam logic [QBS_BIT_W-1:0] LAST_BIT = QBS_BIT_W'(QBS_FRAME_BITS - 1);

  qbs_state_e           state;
  logic [QBS_BIT_W-1:0] bit_idx;
  logic                 pulse_mode;
  logic                 last_bit;
  logic                 high_end;

  assign last_bit = pulse_mode || (bit_idx == LAST_BIT);
  assign high_end = (state == ST_HIGH) && phase_end;
  assign rise_stb = (state == ST_LOW) && phase_end;
  assign fall_stb = high_end && !last_bit;
  assign done_stb = high_end && last_bit && !pulse_mode;
  assign run      = (state != ST_IDLE);
  assign sck      = (state == ST_HIGH);
  assign frame_on = run && !pulse_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bit_idx    <= '0;
      pulse_mode <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cmd_go) begin
            state      <= ST_LOW;
            bit_idx    <= '0;
            pulse_mode <= 1'b0;
          end else if (pulse_go) begin
            state      <= ST_LOW;
            bit_idx    <= '0;
            pulse_mode <= 1'b1;
          end
        end
        ST_LOW: begin
          if (phase_end) state <= ST_HIGH;
        end
        ST_HIGH: begin
          if (phase_end) begin
            if (last_bit) begin
              state      <= ST_IDLE;
              pulse_mode <= 1'b0;
            end else begin
              state   <= ST_LOW;
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qbs_shift_unit.sv
`timescale 1ns/1ps
module qbs_shift_unit
  import qbs_pkg::*;
(
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    load,
  input  logic [QBS_FRAME_BITS-1:0]               tx_word,
  input  logic                                    frame_on,
  input  logic                                    rise_stb,
  input  logic                                    fall_stb,
  input  logic                                    miso,
  output logic                                    mosi,
  output logic [QBS_NUM_BYTES-1:0][QBS_BYTE_W-1:0] rx_bytes
);
  logic [QBS_FRAME_BITS-1:0] tx_sr;
  logic [QBS_FRAME_BITS-1:0] rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
    end else if (load) begin
      tx_sr <= tx_word;
    end else if (fall_stb) begin
      tx_sr <= {tx_sr[QBS_FRAME_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr <= '0;
    end else if (rise_stb && frame_on) begin
      rx_sr <= {rx_sr[QBS_FRAME_BITS-2:0], miso};
    end
  end

  assign mosi = frame_on && tx_sr[QBS_FRAME_BITS-1];

  // Slot 0 holds the earliest byte, i.e. the top of the shift register.
  for (genvar k = 0; k < QBS_NUM_BYTES; k++) begin : g_slot
    assign rx_bytes[k] = rx_sr[QBS_FRAME_BITS-1-k*QBS_BYTE_W -: QBS_BYTE_W];
  end
endmodule

// File: rtl/quad_byte_shifter.sv
`timescale 1ns/1ps
module quad_byte_shifter
  import qbs_pkg::*;
#(
  parameter int unsigned HALF_CYC = 600
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [QBS_FRAME_BITS-1:0] cmd_data,
  input  logic                      pulse_req,
  output logic                      busy,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [QBS_BYTE_W-1:0]     rsp_slot0,
  output logic [QBS_BYTE_W-1:0]     rsp_slot1,
  output logic [QBS_BYTE_W-1:0]     rsp_slot2,
  output logic [QBS_BYTE_W-1:0]     rsp_slot3,
  output logic                      sck,
  output logic                      mosi,
  input  logic                      miso
);
  logic cmd_go, pulse_go, run, phase_end, frame_on;
  logic rise_stb, fall_stb, done_stb;
  logic [QBS_NUM_BYTES-1:0][QBS_BYTE_W-1:0] rx_bytes;

  assign busy      = run;
  assign cmd_ready = !run && !rsp_valid;
  assign cmd_go    = cmd_valid && cmd_ready;
  assign pulse_go  = pulse_req && !run && !cmd_go;

  qbs_phase_timer #(.HALF_CYC(HALF_CYC)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .restart   (cmd_go || pulse_go),
    .phase_end (phase_end)
  );

  qbs_sequencer seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_go    (cmd_go),
    .pulse_go  (pulse_go),
    .phase_end (phase_end),
    .run       (run),
    .sck       (sck),
    .frame_on  (frame_on),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb),
    .done_stb  (done_stb)
  );

  qbs_shift_unit shift_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cmd_go),
    .tx_word  (cmd_data),
    .frame_on (frame_on),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .miso     (miso),
    .mosi     (mosi),
    .rx_bytes (rx_bytes)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else if (done_stb) begin
      rsp_valid <= 1'b1;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_slot0 = rx_bytes[0];
  assign rsp_slot1 = rx_bytes[1];
  assign rsp_slot2 = rx_bytes[2];
  assign rsp_slot3 = rx_bytes[3];
endmodule

// File: rtl/qbs_checker.sv
`timescale 1ns/1ps
module qbs_checker
  import qbs_pkg::*;
#(
  parameter int unsigned HALF_CYC = 600
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic                  cmd_ready,
  input logic                  busy,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [QBS_BYTE_W-1:0] rsp_slot0,
  input logic [QBS_BYTE_W-1:0] rsp_slot1,
  input logic [QBS_BYTE_W-1:0] rsp_slot2,
  input logic [QBS_BYTE_W-1:0] rsp_slot3,
  input logic                  sck,
  input logic                  mosi
);
  logic [31:0] lo_cnt, hi_cnt, rise_cnt;
  logic        sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt   <= '0;
      hi_cnt   <= '0;
      rise_cnt <= '0;
      sck_q    <= 1'b0;
    end else begin
      sck_q  <= sck;
      lo_cnt <= sck ? '0 : ((lo_cnt == '1) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt <= sck ? ((hi_cnt == '1) ? hi_cnt : hi_cnt + 1'b1) : '0;
      if (cmd_valid && cmd_ready) rise_cnt <= '0;
      else if (sck && !sck_q)     rise_cnt <= rise_cnt + 1'b1;
    end
  end

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy); // R2
  AST_SCK_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> lo_cnt >= HALF_CYC); // R3
  AST_SCK_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> hi_cnt >= HALF_CYC); // R3
  AST_MOSI_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$fell(sck) |-> $stable(mosi)); // R4
  AST_FRAME_RISE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> rise_cnt == QBS_FRAME_BITS); // R6
  AST_DONE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> !busy && !sck); // R6
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid &&
      $stable({rsp_slot0, rsp_slot1, rsp_slot2, rsp_slot3})); // R7
  AST_NO_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck && !mosi); // R10
endmodule

bind quad_byte_shifter qbs_checker #(.HALF_CYC(HALF_CYC)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .busy      (busy),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_slot0 (rsp_slot0),
  .rsp_slot1 (rsp_slot1),
  .rsp_slot2 (rsp_slot2),
  .rsp_slot3 (rsp_slot3),
  .sck       (sck),
  .mosi      (mosi)
);

// File: tb/quad_byte_shifter_tb.sv
`timescale 1ns/1ps
module quad_byte_shifter_tb_top;
  localparam int HB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, pulse_req = 1'b0, rsp_ready = 1'b1;
  logic [31:0] cmd_data = '0;
  logic cmd_ready, busy, rsp_valid, sck, mosi, miso;
  logic [7:0] rsp_slot0, rsp_slot1, rsp_slot2, rsp_slot3;

  always #2.5 clk = ~clk;

  quad_byte_shifter #(.HALF_CYC(HB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .pulse_req(pulse_req), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_slot0(rsp_slot0), .rsp_slot1(rsp_slot1),
    .rsp_slot2(rsp_slot2), .rsp_slot3(rsp_slot3),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  int checks = 0;
  int fails  = 0;
  bit go_chk = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- target model ----------------
  logic [31:0] tgt_pattern = '0;
  bit          tgt_echo_en = 0;
  logic [31:0] tgt_rx = '0;
  logic [7:0]  tgt_echo = '0;
  int          tgt_idx = 0;
  int          rises = 0;

  always @(posedge sck) begin
    tgt_rx = {tgt_rx[30:0], mosi};
    rises++;
  end
  always @(negedge sck) begin
    tgt_idx++;
    if (tgt_idx == 16) tgt_echo = tgt_rx[7:0];
  end
  always @* begin
    if (tgt_idx >= 32) miso = 1'b0;
    else if (tgt_echo_en && (tgt_idx / 8) == 2) miso = tgt_echo[7 - (tgt_idx % 8)];
    else miso = tgt_pattern[31 - tgt_idx];
  end

  // ---------------- reference model ----------------
  int          m_mode = 0;   // 0 idle, 1 frame, 2 pulse
  int          m_t = 0, m_len = 0;
  bit          m_rv = 0;
  logic [31:0] m_word = '0, m_slots = '0, m_pend = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_t = 0; m_rv = 0;
    end else begin
      bit pre_ready;
      pre_ready = (m_mode == 0) && !m_rv;
      if (m_rv && rsp_ready) m_rv = 0;
      if (m_mode != 0) begin
        m_t++;
        if (m_t == m_len) begin
          if (m_mode == 1) begin m_rv = 1; m_slots = m_pend; end
          m_mode = 0;
        end
      end else if (cmd_valid && pre_ready) begin
        m_mode = 1; m_t = 0; m_len = 64 * HB; m_word = cmd_data;
        m_pend = {tgt_pattern[31:16],
                  tgt_echo_en ? cmd_data[23:16] : tgt_pattern[15:8],
                  tgt_pattern[7:0]};
      end else if (pulse_req) begin
        m_mode = 2; m_t = 0; m_len = 2 * HB;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && go_chk) begin
      logic e_sck, e_mosi;
      e_sck  = (m_mode != 0) && (((m_t / HB) % 2) == 1);
      e_mosi = (m_mode == 1) ? m_word[31 - m_t / (2 * HB)] : 1'b0;
      chk(m_mode == 2 ? "R8" : (m_mode == 0 ? "R10" : "R3"), "sck", 32'(sck), 32'(e_sck));
      chk(m_mode == 0 ? "R10" : "R4", "mosi", 32'(mosi), 32'(e_mosi));
      chk("R2", "busy", 32'(busy), 32'(m_mode != 0));
      chk("R2", "cmd_ready", 32'(cmd_ready), 32'((m_mode == 0) && !m_rv));
      chk("R6", "rsp_valid", 32'(rsp_valid), 32'(m_rv));
      if (m_rv) chk("R5", "slots", {rsp_slot0, rsp_slot1, rsp_slot2, rsp_slot3}, m_slots);
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic prep(input logic [31:0] pat, input bit echo);
    tgt_pattern = pat; tgt_echo_en = echo; tgt_idx = 0; rises = 0;
  endtask

  task automatic issue(input logic [31:0] w, input logic [31:0] pat, input bit echo);
    while (!cmd_ready) @(negedge clk);
    prep(pat, echo);
    cmd_data = w; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_rsp();
    while (!rsp_valid) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "sck in reset", 32'(sck), 0);
    chk("R1", "rsp_valid in reset", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "sck", 32'(sck), 0);
    chk("R1", "mosi", 32'(mosi), 0);
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "cmd_ready", 32'(cmd_ready), 1);
    chk("R1", "rsp_valid", 32'(rsp_valid), 0);
    go_chk = 1;

    // Echoing target: third slot returns the second command byte.
    issue(32'hAC53_1234, 32'h0F1E_2D3C, 1'b1);
    wait_rsp();
    chk("R6", "rising edges", rises, 32);
    chk("R5", "echo slot2", 32'(rsp_slot2), 32'h53);
    chk("R5", "slot0", 32'(rsp_slot0), 32'h0F);
    chk("R5", "slot3", 32'(rsp_slot3), 32'h3C);
    @(negedge clk);

    // Back-pressure: response held, next word waits.
    rsp_ready = 1'b0;
    issue(32'hFFFF_FFFF, 32'h0000_0000, 1'b0);
    wait_rsp();
    prep(32'h5AA5_C33C, 1'b0);
    cmd_data = 32'h0123_4567; cmd_valid = 1'b1;
    repeat (12) @(negedge clk);
    chk("R7", "rsp_valid held", 32'(rsp_valid), 1);
    chk("R7", "cmd_ready low", 32'(cmd_ready), 0);
    chk("R7", "no accept", 32'(busy), 0);
    chk("R7", "slots held", {rsp_slot0, rsp_slot1, rsp_slot2, rsp_slot3}, 32'h0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R7", "rsp_valid cleared", 32'(rsp_valid), 0);
    while (!busy) @(negedge clk);
    cmd_valid = 1'b0;
    wait_rsp();
    chk("R5", "slots", {rsp_slot0, rsp_slot1, rsp_slot2, rsp_slot3}, 32'h5AA5_C33C);

    // Pulse while a response is pending.
    rises = 0;
    pulse_req = 1'b1;
    @(negedge clk);
    pulse_req = 1'b0;
    chk("R8", "pulse busy", 32'(busy), 1);
    while (busy) @(negedge clk);
    chk("R8", "pulse rising edges", rises, 1);
    chk("R8", "rsp_valid kept", 32'(rsp_valid), 1);
    chk("R8", "slots kept", {rsp_slot0, rsp_slot1, rsp_slot2, rsp_slot3}, 32'h5AA5_C33C);
    rsp_ready = 1'b1;
    @(negedge clk);

    // Pulse together with a word, then pulse in mid-frame: both ignored.
    while (!cmd_ready) @(negedge clk);
    prep(32'h8001_7FFE, 1'b0);
    cmd_data = 32'h0000_0000; cmd_valid = 1'b1; pulse_req = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; pulse_req = 1'b0;
    repeat (20) @(negedge clk);
    pulse_req = 1'b1;
    @(negedge clk);
    pulse_req = 1'b0;
    wait_rsp();
    chk("R9", "rising edges", rises, 32);
    chk("R9", "slots", {rsp_slot0, rsp_slot1, rsp_slot2, rsp_slot3}, 32'h8001_7FFE);
    @(negedge clk);

    issue(32'hC3C3_0FF0, 32'h6699_AA55, 1'b1);
    wait_rsp();
    chk("R5", "echo slot2", 32'(rsp_slot2), 32'hC3);
    chk("R6", "rising edges", rises, 32);
    repeat (10) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule